// File: doc/BRIEF.md
# Gated External Memory Clock Generator

This block derives the clock that is driven to external synchronous memories from the system clock. It divides the system clock by a programmable integer. The clock can run in one of two ways. By default it runs only while a synchronous transaction is in progress, and it stays low when no transaction is active. In the second way it runs without stopping, through asynchronous accesses, synchronous accesses and the idle time between them. That second way requires a continuous-run bit, and the bit is honoured only while bank 1 is set up for synchronous operation. If bank 1 is not synchronous, the block falls back to the gated behaviour.

Every synchronous memory on the bus shares the one output clock. The block also produces a one-cycle strobe, aligned to each rising edge of the output clock, so that the transaction logic can launch and capture data on that edge. The clock only starts or stops at the boundary of a period, so it never produces a shortened high pulse. A new divide ratio is picked up at the start of the next period.

Top module: `memclk_gen`

## Requirements
- R1: Each output period lasts N system cycles, where N is the effective divide ratio. The output is high for the first floor(N/2) cycles of the period and low for the remaining cycles.
- R2: A divide ratio of 0 or 1 is treated as 2, so the output never toggles at the system clock rate and two strobes are never adjacent.
- R3: The divide ratio is sampled on the system clock edge that begins a period. A change made in the middle of a period does not alter that period.
- R4: In gated mode the output is low and no strobe is produced while no transaction is active. When the system clock edge samples `xfer_active` high with the clock idle, a period begins on that edge.
- R5: Once a period has begun it always runs to completion, even if its run condition drops partway through. The clock then stops low at the period boundary.
- R6: When `cont_en` and `bank1_sync` are both 1, the clock runs back-to-back periods whatever the value of `xfer_active`.
- R7: When `bank1_sync` is 0, `cont_en` has no effect. With no transaction active, the output stays low.
- R8: `mclk_rise` is high for exactly one system cycle at the start of each period, which is the first cycle in which `mclk_out` is high. It is low at all other times.
- R9: While `rst_n` is 0 (active low), both `mclk_out` and `mclk_rise` are 0, and the clock is idle when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_ratio | input | DIV_W | Divide ratio N; values below 2 act as 2 |
| cont_en | input | 1 | Request for the continuous-run clock |
| bank1_sync | input | 1 | Bank 1 is configured for synchronous operation |
| xfer_active | input | 1 | A synchronous transaction is in progress |
| mclk_out | output | 1 | Divided external memory clock |
| mclk_rise | output | 1 | One-cycle strobe at each rising edge of mclk_out |

## Verification
A wrong period counter or a wrong latched ratio would show up as a high or low phase of the wrong length. It would appear at the next falling edge or the next rising edge of `mclk_out`, which is at most N system cycles away. A wrong run flag would show up as a clock that keeps running when it should be idle, or as a missing start, within one or two cycles of the change in the run condition. The reference model in the bench predicts both outputs for every cycle, so any of these faults is reported in the cycle where it first appears.

// File: rtl/memclk_gen.sv
module memclk_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic             cont_en,
  input  logic             bank1_sync,
  input  logic             xfer_active,
  output logic             mclk_out,
  output logic             mclk_rise
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  logic             running;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] per;
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] div_eff;
  logic             run_req;
  logic             last;
  logic             start;

  assign run_req = xfer_active | (cont_en & bank1_sync);
  assign div_eff = (div_ratio < MIN_DIV) ? MIN_DIV : div_ratio;
  assign half    = per >> 1;
  assign last    = running && (cnt == per - 1'b1);
  assign start   = run_req && (!running || last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      cnt       <= '0;
      per       <= MIN_DIV;
      mclk_out  <= 1'b0;
      mclk_rise <= 1'b0;
    end else if (start) begin
      running   <= 1'b1;
      cnt       <= '0;
      per       <= div_eff;
      mclk_out  <= 1'b1;
      mclk_rise <= 1'b1;
    end else if (last) begin
      running   <= 1'b0;
      cnt       <= '0;
      mclk_out  <= 1'b0;
      mclk_rise <= 1'b0;
    end else if (running) begin
      cnt       <= cnt + 1'b1;
      mclk_out  <= (cnt + 1'b1) < half;
      mclk_rise <= 1'b0;
    end else begin
      mclk_out  <= 1'b0;
      mclk_rise <= 1'b0;
    end
  end
endmodule

// File: rtl/memclk_gen_chk.sv
module memclk_gen_chk #(
  parameter int DIV_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] div_ratio,
  input logic             cont_en,
  input logic             bank1_sync,
  input logic             xfer_active,
  input logic             mclk_out,
  input logic             mclk_rise,
  input logic             running
);
  logic [DIV_W-1:0] d_q;
  logic [DIV_W-1:0] hi_len;
  logic [DIV_W-1:0] exp_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_q    <= '0;
      hi_len <= '0;
      exp_hi <= '0;
    end else begin
      d_q <= div_ratio;
      if (mclk_rise) begin
        hi_len <= DIV_W'(1);
        exp_hi <= ((d_q < DIV_W'(2)) ? DIV_W'(2) : d_q) >> 1;
      end else if (mclk_out) begin
        hi_len <= hi_len + 1'b1;
      end
    end
  end

  assert_high_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mclk_out) |-> hi_len == exp_hi);

  assert_no_adjacent_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_rise |=> !mclk_rise);

  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !xfer_active && !(cont_en && bank1_sync)) |=> !mclk_out);

  assert_cont_keeps_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cont_en && bank1_sync) |=> running);

  assert_rise_marks_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mclk_out) |-> mclk_rise);

  assert_strobe_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_rise |-> (mclk_out && !$past(mclk_out)));
endmodule

bind memclk_gen memclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .cont_en(cont_en),
  .bank1_sync(bank1_sync), .xfer_active(xfer_active), .mclk_out(mclk_out),
  .mclk_rise(mclk_rise), .running(running)
);

// File: tb/memclk_gen_bench.sv
`timescale 1ns/1ps
module memclk_gen_bench;
  localparam int DIV_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] div_ratio = 4'd4;
  logic             cont_en = 1'b0;
  logic             bank1_sync = 1'b0;
  logic             xfer_active = 1'b0;
  logic             mclk_out;
  logic             mclk_rise;

  int    errors = 0;
  int    checks = 0;
  int    rises = 0;
  int    q[$];
  bit    exp_m = 1'b0;
  bit    exp_r = 1'b0;
  bit    done = 1'b0;
  string tag = "R9";

  always #2.5 clk = ~clk;

  memclk_gen #(.DIV_W(DIV_W)) u_memclk_gen (
    .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .cont_en(cont_en),
    .bank1_sync(bank1_sync), .xfer_active(xfer_active),
    .mclk_out(mclk_out), .mclk_rise(mclk_rise)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      exp_m = 1'b0;
      exp_r = 1'b0;
    end else begin
      if (q.size() == 0 && (xfer_active || (cont_en && bank1_sync))) begin
        int n;
        n = (div_ratio < 2) ? 2 : int'(div_ratio);
        for (int i = 0; i < n; i++) q.push_back(i == 0 ? 2 : (i < n / 2 ? 1 : 0));
      end
      if (q.size() == 0) begin
        exp_m = 1'b0;
        exp_r = 1'b0;
      end else begin
        int v;
        v = q.pop_front();
        exp_m = (v != 0);
        exp_r = (v == 2);
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (mclk_out !== exp_m || mclk_rise !== exp_r) begin
        errors++;
        $display("FAIL %s: mclk=%b rise=%b expected mclk=%b rise=%b at %0t",
                 tag, mclk_out, mclk_rise, exp_m, exp_r, $time);
      end
      if (mclk_rise) rises++;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_rises(input string t, input int got, input int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s: rises=%0d expected %0d", t, got, expv);
    end
  endtask

  initial begin
    int r0;
    wait_cyc(3);
    tag = "R9";
    checks++;
    if (mclk_out !== 1'b0 || mclk_rise !== 1'b0) begin
      errors++;
      $display("FAIL R9: mclk=%b rise=%b expected 0 0", mclk_out, mclk_rise);
    end
    rst_n = 1'b1;
    tag = "R4"; wait_cyc(6);
    xfer_active = 1'b1; wait_cyc(17);
    tag = "R5"; xfer_active = 1'b0; wait_cyc(8);
    tag = "R2"; div_ratio = 4'd1; xfer_active = 1'b1; wait_cyc(9);
    div_ratio = 4'd0; wait_cyc(9);
    tag = "R1"; div_ratio = 4'd5; wait_cyc(13);
    div_ratio = 4'd7; wait_cyc(16);
    div_ratio = 4'd15; wait_cyc(33);
    tag = "R3"; div_ratio = 4'd3; wait_cyc(2); div_ratio = 4'd6; wait_cyc(3);
    div_ratio = 4'd9; wait_cyc(20);
    tag = "R5"; xfer_active = 1'b0; wait_cyc(20);
    tag = "R6"; div_ratio = 4'd4; cont_en = 1'b1; bank1_sync = 1'b1;
    r0 = rises; wait_cyc(41);
    check_rises("R6", rises - r0, 10);
    tag = "R8"; xfer_active = 1'b1; div_ratio = 4'd3; wait_cyc(15);
    xfer_active = 1'b0;
    tag = "R7"; bank1_sync = 1'b0; wait_cyc(20);
    r0 = rises; wait_cyc(30);
    check_rises("R7", rises - r0, 0);
    tag = "R9"; rst_n = 1'b0; cont_en = 1'b1; bank1_sync = 1'b1; wait_cyc(4);
    rst_n = 1'b1; wait_cyc(10);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule